// File: doc/BRIEF.md
# HDLC Channel Interrupt Status Unit

This unit gathers the extended interrupt sources of one HDLC signalling channel. Each source sets a sticky pending bit. A per-source mask and a global mask decide which pending bits software sees and which ones drive the interrupt request. The sources are receive overflow, transmit underrun, bus collision, two timer expiries, a summary of a separate sub-status vector, and a layer-1 indication change. The unit also keeps a small transmit status register. That register shows the framer's busy level and a sticky transmit-FIFO overwrite flag.

Software reaches the registers through a plain port with a 3-bit address, separate write and read strobes, and a registered read bus. Reading the status register acknowledges the bits it returned. Masked sources stay latched and show up once their mask bit is cleared. A bus collision also produces a one-cycle automatic transmitter-reset pulse toward the framer.

Top module: `hdlc_irq_unit`

## Requirements
- R1: The status register (address 0) places receive overflow at bit 7, transmit underrun at bit 6, collision at bit 5, timer 2 expiry at bit 4, sub-status summary at bit 3, indication change at bit 2 and timer 1 expiry at bit 1. Bit 0 always reads 0.
- R2: The mask register (address 1) resets to 0xFF and can be read and written. Its bit 0 always reads 1, whatever value is written.
- R3: A source whose mask bit is 1 reads as 0 in the status register but stays pending. It appears in the status register after its mask bit is written to 0.
- R4: The global mask (address 3, bit 0, reset 0) forces every status bit to read as 0 and holds the interrupt request low while it is 1. Pending bits are kept and appear once it returns to 0.
- R5: A status read clears exactly the bits it returned. Masked pending bits survive the read. An event arriving in the same cycle as the read stays pending.
- R6: The summary bit (bit 3) is set in every cycle in which at least one bit of the sub-status vector is 1.
- R7: A collision pulse sets status bit 5 and drives the transmitter-reset output high for exactly the following cycle.
- R8: The transmit status register (address 2) resets to 0x00. Bit 0 gives the busy level at the read edge, bit 1 gives the overwrite flag, and bits 7 to 2 read 0.
- R9: The overwrite flag is set by an overwrite pulse. Only a write of a 1 to bit 0 of address 4 clears it, and reads never clear it. A pulse in the same cycle as that clearing write leaves the flag set.
- R10: The interrupt request is the OR of all pending bits whose mask bit is 0, forced low by the global mask. It follows the register state in the same cycle.
- R11: Read data appears on the read bus in the cycle after the read strobe and holds until the next read. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_rx_ovf | input | 1 | Receive overflow pulse |
| ev_tx_und | input | 1 | Transmit underrun pulse |
| ev_coll | input | 1 | Bus collision pulse |
| ev_tmr2 | input | 1 | Timer 2 expiry pulse |
| sub_stat | input | SUB_W | Sub-status source vector (level) |
| ev_ind_chg | input | 1 | Layer-1 indication change pulse |
| ev_tmr1 | input | 1 | Timer 1 expiry pulse |
| tx_busy | input | 1 | Framer transmit busy level |
| ev_fifo_ovw | input | 1 | Transmit FIFO overwrite pulse |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| auto_xrst | output | 1 | Automatic transmitter-reset pulse |

## Verification
The bench goes after a read that lands in the same cycle as a new event. A design that cleared the whole pending word would lose that event. It also checks masked sources across a status read: a design that cleared every pending bit would never raise them after unmasking. Global-mask toggling with pending work tests that the unit hides bits without dropping them. The overwrite flag is checked against reads, clearing writes with bit 0 at 0, and same-cycle set-and-clear, so a flag cleared by a read or by the wrong command bit shows up as a read mismatch.

// File: rtl/hdlc_irq_pkg.sv
package hdlc_irq_pkg;
   localparam int REG_W = 8;
   localparam logic [2:0] ADR_STAT = 3'd0;
   localparam logic [2:0] ADR_MASK = 3'd1;
   localparam logic [2:0] ADR_TXST = 3'd2;
   localparam logic [2:0] ADR_GMSK = 3'd3;
   localparam logic [2:0] ADR_CMD  = 3'd4;
   localparam int B_RXOVF = 7;
   localparam int B_TXUND = 6;
   localparam int B_COLL  = 5;
   localparam int B_TMR2  = 4;
   localparam int B_SUB   = 3;
   localparam int B_IND   = 2;
   localparam int B_TMR1  = 1;
   localparam int TX_B_BUSY = 0;
   localparam int TX_B_OVW  = 1;
   localparam int CMD_B_XRST = 0;
   localparam logic [REG_W-1:0] MASK_RST = 8'hFF;
endpackage

// File: rtl/hdlc_irq_latch.sv
module hdlc_irq_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] pend_o
);
   // one sticky cell per source; a set in the clearing cycle wins
   for (genvar i = 0; i < W; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend_o[i] <= 1'b0;
         else if (set_i[i])
            pend_o[i] <= 1'b1;
         else if (clr_i[i])
            pend_o[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/hdlc_irq_txstat.sv
module hdlc_irq_txstat
   import hdlc_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ovw_ev_i,
   input  logic             xrst_cmd_i,
   input  logic             tx_busy_i,
   output logic             ovw_o,
   output logic [REG_W-1:0] stat_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovw_o <= 1'b0;
      else if (ovw_ev_i)
         ovw_o <= 1'b1;
      else if (xrst_cmd_i)
         ovw_o <= 1'b0;
   end

   always_comb begin
      stat_o = '0;
      stat_o[TX_B_BUSY] = tx_busy_i;
      stat_o[TX_B_OVW]  = ovw_o;
   end
endmodule

// File: rtl/hdlc_irq_regs.sv
module hdlc_irq_regs
   import hdlc_irq_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [REG_W-1:0]  wdata_i,
   input  logic [REG_W-1:0]  vis_i,
   input  logic [REG_W-1:0]  txst_i,
   output logic [REG_W-1:0]  mask_o,
   output logic              gmask_o,
   output logic              xrst_cmd_o,
   output logic [REG_W-1:0]  rdata_o
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADR_MASK);
   localparam logic [ADDR_W-1:0] A_TXST = ADDR_W'(ADR_TXST);
   localparam logic [ADDR_W-1:0] A_GMSK = ADDR_W'(ADR_GMSK);
   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(ADR_CMD);

   logic [REG_W-1:0] rmux;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_o  <= MASK_RST;
         gmask_o <= 1'b0;
      end else if (wr_i) begin
         if (addr_i == A_MASK) mask_o  <= wdata_i | REG_W'(1);
         if (addr_i == A_GMSK) gmask_o <= wdata_i[0];
      end
   end

   assign xrst_cmd_o = wr_i && (addr_i == A_CMD) && wdata_i[CMD_B_XRST];

   always_comb begin
      case (addr_i)
         A_STAT:  rmux = vis_i;
         A_MASK:  rmux = mask_o;
         A_TXST:  rmux = txst_i;
         A_GMSK:  rmux = {{(REG_W-1){1'b0}}, gmask_o};
         default: rmux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_o <= '0;
      else if (rd_i)
         rdata_o <= rmux;
   end
endmodule

// File: rtl/hdlc_irq_unit.sv
module hdlc_irq_unit
   import hdlc_irq_pkg::*;
#(
   parameter int SUB_W   = 4,
   parameter int ADDR_W  = 3,
   parameter int IRQ_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_rx_ovf,
   input  logic              ev_tx_und,
   input  logic              ev_coll,
   input  logic              ev_tmr2,
   input  logic [SUB_W-1:0]  sub_stat,
   input  logic              ev_ind_chg,
   input  logic              ev_tmr1,
   input  logic              tx_busy,
   input  logic              ev_fifo_ovw,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              irq,
   output logic              auto_xrst
);
   if (SUB_W < 1) begin : g_bad_sub
      $error("SUB_W must be at least 1");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must be at least 3");
   end
   if (IRQ_REG != 0 && IRQ_REG != 1) begin : g_bad_irq
      $error("IRQ_REG must be 0 or 1");
   end

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);

   logic [REG_W-1:0] set_v, clr_v, pend, vis, mask_q, txst;
   logic             gmask_q, xrst_cmd, ovw_q, stat_rd, irq_d;

   always_comb begin
      set_v          = '0;
      set_v[B_RXOVF] = ev_rx_ovf;
      set_v[B_TXUND] = ev_tx_und;
      set_v[B_COLL]  = ev_coll;
      set_v[B_TMR2]  = ev_tmr2;
      set_v[B_SUB]   = |sub_stat;
      set_v[B_IND]   = ev_ind_chg;
      set_v[B_TMR1]  = ev_tmr1;
   end

   assign vis     = pend & ~mask_q & {REG_W{~gmask_q}};
   assign stat_rd = reg_rd && (reg_addr == A_STAT);
   assign clr_v   = stat_rd ? vis : '0;
   assign irq_d   = |vis;

   hdlc_irq_latch #(.W(REG_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .pend_o(pend)
   );

   hdlc_irq_txstat u_txst (
      .clk(clk), .rst_n(rst_n), .ovw_ev_i(ev_fifo_ovw), .xrst_cmd_i(xrst_cmd),
      .tx_busy_i(tx_busy), .ovw_o(ovw_q), .stat_o(txst)
   );

   hdlc_irq_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr_i(reg_addr), .wr_i(reg_wr), .rd_i(reg_rd),
      .wdata_i(reg_wdata), .vis_i(vis), .txst_i(txst), .mask_o(mask_q),
      .gmask_o(gmask_q), .xrst_cmd_o(xrst_cmd), .rdata_o(reg_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) auto_xrst <= 1'b0;
      else        auto_xrst <= ev_coll;
   end

   if (IRQ_REG == 1) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_d;
      end
   end else begin : g_irq_comb
      assign irq = irq_d;
   end
endmodule

// File: rtl/hdlc_irq_unit_chk.sv
module hdlc_irq_unit_chk #(
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_rx_ovf,
   input logic              ev_coll,
   input logic              ev_fifo_ovw,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [7:0]        reg_wdata,
   input logic [7:0]        pend,
   input logic [7:0]        mask_q,
   input logic              gmask_q,
   input logic              ovw_q,
   input logic              auto_xrst,
   input logic              irq
);
   // R1
   pend_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n) !pend[0]);
   // R5
   rx_ovf_kept_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_rx_ovf |=> pend[7]);
   // R3
   masked_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[7] && mask_q[7]) |=> pend[7]);
   // R7
   coll_pend_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_coll |=> pend[5]);
   // R7
   xrst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_coll |=> auto_xrst);
   // R7
   xrst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !ev_coll |=> !auto_xrst);
   // R9
   ovw_set_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_fifo_ovw |=> ovw_q);
   // R9
   ovw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovw_q && !(reg_wr && reg_addr == ADDR_W'(4) && reg_wdata[0])) |=> ovw_q);
   // R4
   gmask_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gmask_q && $past(gmask_q)) |-> !irq);
   // R10
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> |(pend & ~mask_q));
endmodule

bind hdlc_irq_unit hdlc_irq_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ev_rx_ovf(ev_rx_ovf), .ev_coll(ev_coll),
   .ev_fifo_ovw(ev_fifo_ovw), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .pend(pend), .mask_q(mask_q), .gmask_q(gmask_q),
   .ovw_q(ovw_q), .auto_xrst(auto_xrst), .irq(irq)
);

// File: tb/hdlc_irq_unit_bench.sv
`timescale 1ns/1ps
module hdlc_irq_unit_bench;
   localparam int SUB_W = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ev_rx_ovf = 0, ev_tx_und = 0, ev_coll = 0, ev_tmr2 = 0;
   logic [SUB_W-1:0] sub_stat = '0;
   logic ev_ind_chg = 0, ev_tmr1 = 0, tx_busy = 0, ev_fifo_ovw = 0;
   logic [2:0] reg_addr = '0;
   logic reg_wr = 0, reg_rd = 0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic irq, auto_xrst;

   always #2.5 clk = ~clk;

   hdlc_irq_unit #(.SUB_W(SUB_W)) u_hdlc_irq_unit (
      .clk(clk), .rst_n(rst_n), .ev_rx_ovf(ev_rx_ovf), .ev_tx_und(ev_tx_und),
      .ev_coll(ev_coll), .ev_tmr2(ev_tmr2), .sub_stat(sub_stat),
      .ev_ind_chg(ev_ind_chg), .ev_tmr1(ev_tmr1), .tx_busy(tx_busy),
      .ev_fifo_ovw(ev_fifo_ovw), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq), .auto_xrst(auto_xrst)
   );

   // bench model of the register state
   logic [7:0] m_pend = '0, m_mask = 8'hFF, m_rdata = '0;
   logic       m_gm = 0, m_ovw = 0, m_xrst = 0;
   int n_chk = 0, n_bad = 0;
   string tag = "";
   bit done = 0;

   function automatic logic [7:0] f_vis(logic [7:0] p, logic [7:0] m, logic g);
      return g ? 8'h00 : (p & ~m);
   endfunction

   function automatic logic [7:0] f_set();
      return {ev_rx_ovf, ev_tx_und, ev_coll, ev_tmr2, |sub_stat, ev_ind_chg, ev_tmr1, 1'b0};
   endfunction

   function automatic logic [7:0] f_read(logic [2:0] a);
      case (a)
         3'd0: return f_vis(m_pend, m_mask, m_gm);
         3'd1: return m_mask;
         3'd2: return {6'b0, m_ovw, tx_busy};
         3'd3: return {7'b0, m_gm};
         default: return 8'h00;
      endcase
   endfunction

   function automatic string f_tag(logic [2:0] a);
      case (a)
         3'd0: return "R5";
         3'd1: return "R2";
         3'd2: return "R8";
         3'd3: return "R4";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h at %0t", r, act, exp, $time);
      end
   endtask

   // applies the inputs currently driven for one clock and checks every output
   task automatic step();
      logic [7:0] s, c;
      string rt;
      rt = (tag != "") ? tag : f_tag(reg_addr);
      s = f_set();
      c = 8'h00;
      if (reg_rd) begin
         m_rdata = f_read(reg_addr);
         if (reg_addr == 3'd0) c = f_vis(m_pend, m_mask, m_gm);
      end
      m_xrst = ev_coll;
      m_pend = (m_pend & ~c) | s;
      if (reg_wr && reg_addr == 3'd1) m_mask = reg_wdata | 8'h01;
      if (reg_wr && reg_addr == 3'd3) m_gm = reg_wdata[0];
      if (reg_wr && reg_addr == 3'd4 && reg_wdata[0]) m_ovw = 1'b0;
      if (ev_fifo_ovw) m_ovw = 1'b1;
      @(posedge clk);
      #1;
      chk((reg_rd ? rt : "R11"), reg_rdata, m_rdata);
      chk("R10", {7'b0, irq}, {7'b0, |f_vis(m_pend, m_mask, m_gm)});
      chk("R7", {7'b0, auto_xrst}, {7'b0, m_xrst});
      @(negedge clk);
      ev_rx_ovf = 0; ev_tx_und = 0; ev_coll = 0; ev_tmr2 = 0;
      ev_ind_chg = 0; ev_tmr1 = 0; ev_fifo_ovw = 0;
      reg_rd = 0; reg_wr = 0;
   endtask

   task automatic rd(logic [2:0] a);
      reg_addr = a; reg_rd = 1; step();
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      reg_addr = a; reg_wr = 1; reg_wdata = d; step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd6692));
      repeat (3) @(negedge clk);
      // reset state checked at the ports
      chk("R11", reg_rdata, 8'h00);
      chk("R10", {7'b0, irq}, 8'h00);
      rst_n = 1;
      @(negedge clk);
      rd(3'd1); rd(3'd2); rd(3'd0); rd(3'd3); rd(3'd6);

      // R1: each source on its own bit, mask write of 0 keeps bit 0 at 1 (R2)
      wr(3'd1, 8'h00); rd(3'd1);
      tag = "R1";
      ev_rx_ovf = 1; step(); rd(3'd0);
      ev_tx_und = 1; step(); rd(3'd0);
      ev_coll = 1; step(); rd(3'd0);
      ev_tmr2 = 1; step(); rd(3'd0);
      ev_ind_chg = 1; step(); rd(3'd0);
      ev_tmr1 = 1; step(); rd(3'd0);
      rd(3'd0);

      // R3: masked event hidden, survives a read, shows after unmask
      tag = "R3";
      wr(3'd1, 8'hFF);
      ev_rx_ovf = 1; ev_tmr2 = 1; step();
      rd(3'd0); rd(3'd0);
      wr(3'd1, 8'h7F); rd(3'd0);
      wr(3'd1, 8'h00); rd(3'd0); rd(3'd0);

      // R5: event in the same cycle as the read stays pending
      tag = "R5";
      ev_tmr1 = 1; step();
      ev_tmr1 = 1; rd(3'd0);
      rd(3'd0); rd(3'd0);
      wr(3'd1, 8'h0F); ev_tx_und = 1; ev_tmr1 = 1; step();
      rd(3'd0); wr(3'd1, 8'h00); rd(3'd0);

      // R6: summary follows the sub-status level
      tag = "R6";
      sub_stat = 4'b0100; step(); rd(3'd0); rd(3'd0);
      sub_stat = 4'b0000; rd(3'd0); rd(3'd0);
      sub_stat = 4'b1000; step(); sub_stat = 4'b0000; rd(3'd0);

      // R4: global mask hides without dropping
      tag = "R4";
      wr(3'd3, 8'h01); rd(3'd3);
      ev_coll = 1; step(); rd(3'd0); step();
      wr(3'd3, 8'h00); rd(3'd0); rd(3'd0);

      // R9 and R8: overwrite flag only cleared by the command bit
      tag = "R9";
      ev_fifo_ovw = 1; step(); rd(3'd2); rd(3'd2);
      wr(3'd4, 8'hFE); rd(3'd2);
      ev_fifo_ovw = 1; reg_addr = 3'd4; reg_wr = 1; reg_wdata = 8'h01; step(); rd(3'd2);
      wr(3'd4, 8'h01); rd(3'd2);
      tag = "R8";
      tx_busy = 1; rd(3'd2); tx_busy = 0; rd(3'd2);
      tag = "";

      // constrained random phase
      for (int i = 0; i < 4000; i++) begin
         int op;
         ev_rx_ovf  = ($urandom % 8) == 0;
         ev_tx_und  = ($urandom % 8) == 0;
         ev_coll    = ($urandom % 10) == 0;
         ev_tmr2    = ($urandom % 8) == 0;
         ev_ind_chg = ($urandom % 8) == 0;
         ev_tmr1    = ($urandom % 8) == 0;
         ev_fifo_ovw = ($urandom % 16) == 0;
         sub_stat   = (($urandom % 6) == 0) ? SUB_W'($urandom) : '0;
         tx_busy    = $urandom % 2;
         op = $urandom % 8;
         reg_addr = ($urandom % 4 == 0) ? 3'($urandom) : 3'd0;
         reg_wdata = 8'($urandom);
         if (op < 3) reg_rd = 1;
         else if (op == 3) reg_wr = 1;
         step();
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule